// File: doc/BRIEF.md
# Serial Audio Bit Clock and Word-Select Generator

This block is the clock-provider half of a two-channel serial audio port. Running off the system clock, it makes the serial bit clock as a level plus a pair of one-cycle enable pulses. The pulses tell the data shifters when the bit clock is about to rise or fall. It also drives the word-select line, which marks the left and right halves of each audio frame, and it gives a one-cycle marker whenever a new slot begins.

Two enables gate the generator: a block-wide enable and a clock enable. The generator runs only while both are set. Whenever either is clear, the bit clock and word-select are held low and any partial frame is thrown away, so the next start always begins a fresh left slot.

A divider input sets the bit-clock rate. A coded slot-length field chooses 16, 24 or 32 bit clocks per word-select half-period, so each frame carries two slots and the bit clock runs at sample rate times slot width times two.

Top module: `aud_sclk_gen`

## Requirements
- R1: After reset, sck_o, ws_o, sck_rise_o, sck_fall_o and slot_start_o are all 0.
- R2: While running, sck_o has a period of 2*(div_i+1) system cycles with equal high and low halves. The first high phase begins div_i+1 cycles after the clock edge that first sees the generator running.
- R3: sck_rise_o (sck_fall_o) is high for exactly one cycle, in the cycle just before sck_o goes from 0 to 1 (1 to 0). The two pulses are never high together, and both are 0 whenever the generator is not running.
- R4: The slot length is decoded from slot_cfg_i bits [4:3] only: 2'b00 gives 16 bit clocks, 2'b01 gives 24, and 2'b10 or 2'b11 give 32. Bits [2:0] have no effect.
- R5: ws_o is 0 (left slot) when the generator starts. It toggles only on the clock edge where sck_o falls, after exactly the slot length of bit-clock falls in the current slot.
- R6: slot_start_o is high for one cycle, in the cycle in which ws_o has just toggled while running. It is never high otherwise.
- R7: While clk_en_i is 0, sck_o and ws_o are held at 0 from the next clock edge on, and no pulses are emitted.
- R8: While glb_en_i is 0, the outputs are held idle exactly as in R7, regardless of clk_en_i.
- R9: A disable in mid-frame abandons the frame. After re-enable the first slot is a left slot of full length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| glb_en_i | input | 1 | Block-wide enable |
| clk_en_i | input | 1 | Bit-clock generator enable |
| div_i | input | DIV_W (16) | Divider value; bit-clock period is 2*(div_i+1) cycles |
| slot_cfg_i | input | 5 | Slot-length code, bits [4:3] decoded |
| sck_o | output | 1 | Bit-clock level |
| sck_rise_o | output | 1 | Pulse one cycle before the bit clock rises |
| sck_fall_o | output | 1 | Pulse one cycle before the bit clock falls |
| ws_o | output | 1 | Word select, 0 = left slot, 1 = right slot |
| slot_start_o | output | 1 | One-cycle marker of each word-select toggle |

## Verification
The bench builds the block with the default 16-bit divider and sweeps div_i over 0, 1, 2 and 3. These values give bit-clock periods from 2 to 8 system cycles while keeping 32-bit slots short enough that many complete frames fit in the run. All four slot-length codes are applied, one of them with the ignored low bits set, so every decode path is exercised. Disables are issued through each enable separately and in mid-frame, which reaches the abandon-and-restart path and the held-idle state.

// File: rtl/aud_clk_pkg.sv
package aud_clk_pkg;

  localparam int CFG_W = 5;
  localparam int LEN_W = 6;

  typedef enum logic [1:0] {
    SLOT_16  = 2'b00,
    SLOT_24  = 2'b01,
    SLOT_32  = 2'b10,
    SLOT_32B = 2'b11
  } slot_code_e;

  function automatic logic [LEN_W-1:0] slot_bits(input slot_code_e code);
    case (code)
      SLOT_16: slot_bits = LEN_W'(16);
      SLOT_24: slot_bits = LEN_W'(24);
      default: slot_bits = LEN_W'(32);
    endcase
  endfunction

endpackage

// File: rtl/aud_len_dec.sv
module aud_len_dec
  import aud_clk_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  output logic [LEN_W-1:0] len_o
);

  slot_code_e code;

  always_comb begin
    code  = slot_code_e'(cfg_i[4:3]);
    len_o = slot_bits(code);
  end

endmodule

// File: rtl/aud_sclk_div.sv
module aud_sclk_div #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             rise_o,
  output logic             fall_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;
  logic             sck_q, sck_d;
  logic             tick;

  assign tick = run_i && (cnt_q >= div_i);

  always_comb begin
    cnt_d = cnt_q;
    sck_d = sck_q;
    if (!run_i) begin
      cnt_d = '0;
      sck_d = 1'b0;
    end else if (tick) begin
      cnt_d = '0;
      sck_d = ~sck_q;
    end else begin
      cnt_d = cnt_q + DIV_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sck_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sck_q <= sck_d;
    end
  end

  assign sck_o  = sck_q;
  assign rise_o = tick && !sck_q;
  assign fall_o = tick && sck_q;

endmodule

// File: rtl/aud_ws_seq.sv
module aud_ws_seq
  import aud_clk_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic             fall_i,
  input  logic [LEN_W-1:0] len_i,
  output logic             ws_o,
  output logic             slot_start_o
);

  logic [LEN_W-1:0] bits_q, bits_d;
  logic             ws_q, ws_d;
  logic             ss_q, ss_d;
  logic             last_bit;

  assign last_bit = bits_q >= (len_i - LEN_W'(1));

  always_comb begin
    bits_d = bits_q;
    ws_d   = ws_q;
    ss_d   = 1'b0;
    if (!run_i) begin
      bits_d = '0;
      ws_d   = 1'b0;
    end else if (fall_i) begin
      if (last_bit) begin
        bits_d = '0;
        ws_d   = ~ws_q;
        ss_d   = 1'b1;
      end else begin
        bits_d = bits_q + LEN_W'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bits_q <= '0;
      ws_q   <= 1'b0;
      ss_q   <= 1'b0;
    end else begin
      bits_q <= bits_d;
      ws_q   <= ws_d;
      ss_q   <= ss_d;
    end
  end

  assign ws_o         = ws_q;
  assign slot_start_o = ss_q;

endmodule

// File: rtl/aud_sclk_gen.sv
module aud_sclk_gen
  import aud_clk_pkg::*;
#(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             glb_en_i,
  input  logic             clk_en_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [CFG_W-1:0] slot_cfg_i,
  output logic             sck_o,
  output logic             sck_rise_o,
  output logic             sck_fall_o,
  output logic             ws_o,
  output logic             slot_start_o
);

  logic             run;
  logic [LEN_W-1:0] slot_len;

  assign run = glb_en_i && clk_en_i;

  aud_len_dec u_dec (
    .cfg_i (slot_cfg_i),
    .len_o (slot_len)
  );

  aud_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (run),
    .div_i  (div_i),
    .sck_o  (sck_o),
    .rise_o (sck_rise_o),
    .fall_o (sck_fall_o)
  );

  aud_ws_seq u_ws (
    .clk          (clk),
    .rst_n        (rst_n),
    .run_i        (run),
    .fall_i       (sck_fall_o),
    .len_i        (slot_len),
    .ws_o         (ws_o),
    .slot_start_o (slot_start_o)
  );

endmodule

// File: rtl/aud_sclk_gen_chk.sv
module aud_sclk_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic glb_en_i,
  input logic clk_en_i,
  input logic sck_o,
  input logic sck_rise_o,
  input logic sck_fall_o,
  input logic ws_o,
  input logic slot_start_o
);

  logic run;
  assign run = glb_en_i && clk_en_i;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en_i |=> (!sck_o && !ws_o && !slot_start_o)); // R7

  AST_GLB_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !glb_en_i |=> (!sck_o && !ws_o && !slot_start_o)); // R8

  AST_NO_PULSE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> (!sck_rise_o && !sck_fall_o)); // R3

  AST_RISE_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sck_rise_o |=> sck_o); // R3

  AST_FALL_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    sck_fall_o |=> !sck_o); // R3

  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sck_rise_o && sck_fall_o)); // R3

  AST_SCK_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && !$past(sck_rise_o) && !$past(sck_fall_o)) |-> $stable(sck_o)); // R2

  AST_WS_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && (ws_o != $past(ws_o))) |-> $past(sck_fall_o)); // R5

  AST_SLOT_MARK: assert property (@(posedge clk) disable iff (!rst_n)
    slot_start_o |-> (ws_o != $past(ws_o))); // R6

endmodule

bind aud_sclk_gen aud_sclk_gen_chk u_chk (.*);

// File: tb/sim_aud_sclk_gen.sv
`timescale 1ns/1ps
module sim_aud_sclk_gen;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        glb_en, clk_en;
  logic [15:0] div;
  logic [4:0]  cfg;
  logic        sck, rise, fall, ws, ss;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  aud_sclk_gen u0 (
    .clk(clk), .rst_n(rst_n), .glb_en_i(glb_en), .clk_en_i(clk_en),
    .div_i(div), .slot_cfg_i(cfg), .sck_o(sck), .sck_rise_o(rise),
    .sck_fall_o(fall), .ws_o(ws), .slot_start_o(ss)
  );

  // Slot length per R4
  function automatic int exp_len(input logic [4:0] c);
    if (c[4:3] == 2'b00) return 16;
    if (c[4:3] == 2'b01) return 24;
    return 32;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // Behavioural reference state
  int m_cnt = 0, m_bits = 0;
  bit m_sck = 0, m_ws = 0, m_ss = 0;
  bit prev_run = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_sck = 0; m_bits = 0; m_ws = 0; m_ss = 0; prev_run = 0;
    end else begin
      prev_run = glb_en && clk_en;
      m_ss = 0;
      if (!(glb_en && clk_en)) begin
        m_cnt = 0; m_sck = 0; m_bits = 0; m_ws = 0;
      end else if (m_cnt >= int'(div)) begin
        m_cnt = 0;
        if (m_sck) begin
          if (m_bits >= exp_len(cfg) - 1) begin
            m_bits = 0; m_ws = !m_ws; m_ss = 1;
          end else m_bits++;
        end
        m_sck = !m_sck;
      end else m_cnt++;
    end
  end

  // Port-level measurements
  int falls_seen = 0;
  int since_rise = 0;
  bit have_rise  = 0;
  bit sck_prev   = 0;
  bit meas_on    = 0;

  always @(negedge clk) begin
    if (rst_n && meas_on) begin
      bit run_now, m_tick;
      run_now = glb_en && clk_en;
      m_tick  = run_now && (m_cnt >= int'(div));
      chk("R2 sck", sck, m_sck);
      chk("R3 rise", rise, m_tick && !m_sck);
      chk("R3 fall", fall, m_tick && m_sck);
      chk("R5 ws", ws, m_ws);
      chk("R6 slot_start", ss, m_ss);
      if (!prev_run) begin
        if (!clk_en) chk("R7 idle", {sck, ws, ss}, 0);
        if (!glb_en) chk("R8 idle", {sck, ws, ss}, 0);
        falls_seen = 0;
        have_rise  = 0;
        since_rise = 0;
      end else begin
        since_rise++;
        if (sck && !sck_prev) begin
          if (have_rise) chk("R2 period", since_rise, 2 * (int'(div) + 1));
          have_rise  = 1;
          since_rise = 0;
        end
        if (ss) begin
          chk("R4/R9 slot length", falls_seen, exp_len(cfg));
          falls_seen = 0;
        end
      end
      if (fall) falls_seen++;
      sck_prev = sck;
    end
  end

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic set_run(input bit g, input bit c, input int d, input logic [4:0] f);
    glb_en = g; clk_en = c; div = 16'(d); cfg = f;
  endtask

  initial begin
    rst_n = 1'b0;
    set_run(0, 0, 0, 5'h00);
    step(4);
    chk("R1 reset sck", sck, 0);
    chk("R1 reset ws", ws, 0);
    chk("R1 reset pulses", {rise, fall, ss}, 0);
    rst_n = 1'b1;
    step(2);
    meas_on = 1'b1;
    chk("R1 after release", {sck, ws, rise, fall, ss}, 0);

    set_run(1, 1, 0, 5'h00);           // 16-bit slots, fastest clock
    step(300);
    clk_en = 1'b0;                     // R7 mid-frame disable
    step(20);
    set_run(1, 1, 1, 5'h08);           // R9 restart, 24-bit slots
    step(420);
    glb_en = 1'b0;                     // R8 global gate
    step(20);
    set_run(0, 1, 2, 5'h10);
    step(10);
    glb_en = 1'b1;                     // 32-bit slots
    step(700);
    set_run(1, 0, 0, 5'h1F);           // R4 code 11 with low bits set
    step(5);
    clk_en = 1'b1;
    step(300);
    set_run(0, 0, 3, 5'h0F);           // R4 code 01 with low bits set
    step(5);
    set_run(1, 1, 3, 5'h0F);
    step(900);
    clk_en = 1'b0;
    step(10);
    chk("R7 final idle", {sck, ws, rise, fall, ss}, 0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

endmodule